// File: doc/BRIEF.md
# I2C Receive Shift Register with Bit-Count Snapshot

This block is the receive side of an I2C byte engine. It brings the raw SCL and SDA lines into the system clock domain through two-flop synchronisers. It detects SCL edges on the synchronised clock line and, while the frame-active input is high, shifts one SDA bit into an 8-bit register on each SCL rising edge, most significant bit first. A 4-bit bit counter tracks progress through the byte. When the eighth bit has been taken, the counter is forced to the completion code 4'hF. The counter holds that code until the acknowledge bit has finished.

Software reads the shift register and the counter together through a single 16-bit read. Both values are latched on the same clock edge, so the pair is always consistent, even while bits are arriving. Once a byte is complete, the block raises a hold request that a pad stage uses to stretch SCL low. Software can then read the finished byte before it chooses ACK or NACK. Writing that choice drops the hold. For an ACK, the block pulls SDA low through the ninth clock. START detection, arbitration, pad drivers and the transmit path belong to neighbouring blocks.

Top module: `i2c_rx_shifter`

## Requirements
- R1: While `rst_n` is low, and after it is released, the shift register, bit counter, `rd_data`, `hold_scl` and `ack_pull_sda` are all zero.
- R2: On each synchronised SCL rising edge while `frame_active` is high and the counter is below 8, the register shifts left and takes the SDA value into bit 0, so the first bit received ends up in bit 7.
- R3: SCL rising edges while `frame_active` is low change neither the shift register nor the counter.
- R4: After the k-th data bit (k = 1..7), the counter reads k. In a read word, `rd_data[7:0]` is the shift register, `rd_data[11:8]` is the counter and `rd_data[15:12]` is zero.
- R5: The eighth data bit sets the counter to 4'hF and raises `hold_scl`. A read then returns 4'hF together with the complete received byte.
- R6: While `hold_scl` is high, further SCL edges change neither the shift register nor the counter.
- R7: A pulse on `ack_wr` while `hold_scl` is high lowers `hold_scl` on the next clock. If `ack_nack` was 0 (ACK), `ack_pull_sda` is high from then until the SCL falling edge that follows the ninth rising edge. If `ack_nack` was 1 (NACK), `ack_pull_sda` stays low.
- R8: The SCL falling edge that ends the acknowledge bit returns the counter to 0 and lowers `ack_pull_sda`, and the next byte is received the same way.
- R9: A pulse on `ack_wr` while `hold_scl` is low has no effect: `ack_pull_sda` stays low and the counter and shift register are unchanged.
- R10: A pulse on `start_pulse` clears the counter, `hold_scl` and `ack_pull_sda` on the next clock and leaves the shift register contents unchanged.
- R11: A pulse on `rd_en` latches the counter and shift register values from that same clock edge into `rd_data`. `rd_data` holds them until the next read. A read on the edge where a bit is shifted in returns the pair as it was before that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| frame_active | input | 1 | High while a transfer frame is in progress |
| start_pulse | input | 1 | One-cycle pulse on START or repeated START |
| rd_en | input | 1 | One-cycle read strobe that latches the snapshot word |
| rd_data | output | 16 | Snapshot word: {4'b0, counter, shift register} |
| ack_wr | input | 1 | One-cycle write of the acknowledge choice |
| ack_nack | input | 1 | Acknowledge choice: 0 = ACK, 1 = NACK |
| hold_scl | output | 1 | Request to hold SCL low while a complete byte waits |
| ack_pull_sda | output | 1 | Request to drive SDA low for an ACK |

## Verification
A snapshot read and a bit shift can fall on the same clock edge. In that case the read must return the pair from before the shift, and must not pair an old counter with new data. The bench provokes this by counting the two synchroniser stages and the edge-detect stage from its SCL drive. It places `rd_en` exactly on the edge that updates the register, expects the pre-shift counter and data, and then expects the post-shift pair from a following read. A second coincidence occurs when an `ack_wr` arrives outside the hold window, at a time when no byte is complete. It is judged from the counter, the data and `ack_pull_sda`, which must all stay as they were.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
  localparam int unsigned DATA_W      = 8;
  localparam int unsigned CNT_W       = 4;
  localparam int unsigned RD_W        = 16;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    PH_DATA   = 2'd0,
    PH_WAIT   = 2'd1,
    PH_ACK_LO = 2'd2,
    PH_ACK_HI = 2'd3
  } rx_phase_t;
endpackage

// File: rtl/i2c_rx_sync.sv
module i2c_rx_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[gi] <= RST_VAL;
          else        stage_q[gi] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[gi] <= RST_VAL;
          else        stage_q[gi] <= stage_q[gi-1];
        end
      end
    end
  endgenerate

  assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/i2c_rx_edge.sv
module i2c_rx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic line_s,
  output logic rise,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= line_s;
  end

  assign rise = line_s & ~prev_q;
  assign fall = ~line_s & prev_q;
endmodule

// File: rtl/i2c_rx_core.sv
module i2c_rx_core
  import i2c_rx_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_bit,
  input  logic          frame_active,
  input  logic          start_pulse,
  input  logic          ack_wr,
  input  logic          ack_nack,
  output logic [DW-1:0] shift_o,
  output logic [CW-1:0] cnt_o,
  output logic          hold_o,
  output logic          pull_o
);
  localparam logic [CW-1:0] LAST_IDX  = CW'(DW - 1);
  localparam logic [CW-1:0] DONE_CODE = '1;

  rx_phase_t     phase_q, phase_d;
  logic [DW-1:0] shift_q, shift_d;
  logic [CW-1:0] cnt_q,   cnt_d;
  logic          nack_q,  nack_d;
  logic          shift_en;

  assign shift_en = (phase_q == PH_DATA) && scl_rise && frame_active && !start_pulse;

  always_comb begin
    phase_d = phase_q;
    shift_d = shift_q;
    cnt_d   = cnt_q;
    nack_d  = nack_q;
    if (start_pulse) begin
      phase_d = PH_DATA;
      cnt_d   = '0;
      nack_d  = 1'b0;
    end else begin
      unique case (phase_q)
        PH_DATA: begin
          if (shift_en) begin
            shift_d = {shift_q[DW-2:0], sda_bit};
            if (cnt_q == LAST_IDX) begin
              cnt_d   = DONE_CODE;
              phase_d = PH_WAIT;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        PH_WAIT: begin
          if (ack_wr) begin
            nack_d  = ack_nack;
            phase_d = PH_ACK_LO;
          end
        end
        PH_ACK_LO: begin
          if (scl_rise) phase_d = PH_ACK_HI;
        end
        PH_ACK_HI: begin
          if (scl_fall) begin
            phase_d = PH_DATA;
            cnt_d   = '0;
            nack_d  = 1'b0;
          end
        end
        default: phase_d = PH_DATA;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_DATA;
      shift_q <= '0;
      cnt_q   <= '0;
      nack_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      shift_q <= shift_d;
      cnt_q   <= cnt_d;
      nack_q  <= nack_d;
    end
  end

  assign shift_o = shift_q;
  assign cnt_o   = cnt_q;
  assign hold_o  = (phase_q == PH_WAIT);
  assign pull_o  = ((phase_q == PH_ACK_LO) || (phase_q == PH_ACK_HI)) && !nack_q;
endmodule

// File: rtl/i2c_rx_shifter.sv
module i2c_rx_shifter
  import i2c_rx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_in,
  input  logic            sda_in,
  input  logic            frame_active,
  input  logic            start_pulse,
  input  logic            rd_en,
  output logic [RD_W-1:0] rd_data,
  input  logic            ack_wr,
  input  logic            ack_nack,
  output logic            hold_scl,
  output logic            ack_pull_sda
);
  logic [1:0]        line_s;
  logic              scl_rise, scl_fall;
  logic [DATA_W-1:0] shift_w;
  logic [CNT_W-1:0]  cnt_w;
  logic [RD_W-1:0]   rd_q, rd_d;

  i2c_rx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({scl_in, sda_in}),
    .q_out (line_s)
  );

  i2c_rx_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_s (line_s[1]),
    .rise   (scl_rise),
    .fall   (scl_fall)
  );

  i2c_rx_core #(.DW(DATA_W), .CW(CNT_W)) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_rise     (scl_rise),
    .scl_fall     (scl_fall),
    .sda_bit      (line_s[0]),
    .frame_active (frame_active),
    .start_pulse  (start_pulse),
    .ack_wr       (ack_wr),
    .ack_nack     (ack_nack),
    .shift_o      (shift_w),
    .cnt_o        (cnt_w),
    .hold_o       (hold_scl),
    .pull_o       (ack_pull_sda)
  );

  always_comb begin
    rd_d = rd_q;
    if (rd_en) begin
      rd_d                      = '0;
      rd_d[DATA_W-1:0]          = shift_w;
      rd_d[DATA_W +: CNT_W]     = cnt_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/i2c_rx_checker.sv
module i2c_rx_checker
  import i2c_rx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              frame_active,
  input logic              start_pulse,
  input logic              rd_en,
  input logic              ack_wr,
  input logic [RD_W-1:0]   rd_data,
  input logic              hold_scl,
  input logic              ack_pull_sda,
  input logic [DATA_W-1:0] shift_w,
  input logic [CNT_W-1:0]  cnt_w
);
  AST_CNT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_w < CNT_W'(DATA_W)) || (cnt_w == '1)); // R4

  AST_HOLD_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_scl) |-> (cnt_w == '1) && ($past(cnt_w) == CNT_W'(DATA_W - 1))); // R5

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_scl && !start_pulse) |=> $stable(shift_w) && (cnt_w == '1)); // R6

  AST_NO_PULL_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hold_scl |-> !ack_pull_sda); // R7

  AST_IDLE_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !hold_scl && !ack_pull_sda) |=> !ack_pull_sda); // R9

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> (cnt_w == '0) && !hold_scl && !ack_pull_sda && $stable(shift_w)); // R10

  AST_FRAME_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_active && !hold_scl) |=> $stable(shift_w)); // R3

  AST_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (rd_data[DATA_W-1:0] == $past(shift_w)) &&
              (rd_data[DATA_W +: CNT_W] == $past(cnt_w))); // R11
endmodule

bind i2c_rx_shifter i2c_rx_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_active (frame_active),
  .start_pulse  (start_pulse),
  .rd_en        (rd_en),
  .ack_wr       (ack_wr),
  .rd_data      (rd_data),
  .hold_scl     (hold_scl),
  .ack_pull_sda (ack_pull_sda),
  .shift_w      (shift_w),
  .cnt_w        (cnt_w)
);

// File: tb/i2c_rx_shifter_bench.sv
module i2c_rx_shifter_bench;
  logic        clk;
  logic        rst_n;
  logic        scl_in, sda_in, frame_active, start_pulse;
  logic        rd_en, ack_wr, ack_nack;
  logic [15:0] rd_data;
  logic        hold_scl, ack_pull_sda;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_shift;

  i2c_rx_shifter u_i2c_rx_shifter (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_in       (scl_in),
    .sda_in       (sda_in),
    .frame_active (frame_active),
    .start_pulse  (start_pulse),
    .rd_en        (rd_en),
    .rd_data      (rd_data),
    .ack_wr       (ack_wr),
    .ack_nack     (ack_nack),
    .hold_scl     (hold_scl),
    .ack_pull_sda (ack_pull_sda)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // byte value in [8:1], ACK choice in [0] (1 = NACK)
  localparam logic [8:0] VEC [6] = '{
    {8'hA5, 1'b0}, {8'h3C, 1'b1}, {8'hFF, 1'b0},
    {8'h00, 1'b0}, {8'h81, 1'b1}, {8'h5A, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic scl_pulse(input logic b);
    sda_in = b;
    wait_n(4);
    scl_in = 1'b1;
    wait_n(4);
    scl_in = 1'b0;
    wait_n(4);
  endtask

  task automatic do_read();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic send_data_bit(input logic b);
    scl_pulse(b);
    exp_shift = {exp_shift[6:0], b};
  endtask

  task automatic ack_write(input logic nk);
    ack_nack = nk;
    ack_wr   = 1'b1;
    @(negedge clk);
    ack_wr   = 1'b0;
  endtask

  task automatic ninth_clock(input logic nk);
    sda_in = 1'b1;
    wait_n(4);
    scl_in = 1'b1;
    wait_n(4);
    chk("R7 pull during ninth clock", 32'(ack_pull_sda), 32'(!nk));
    scl_in = 1'b0;
    wait_n(4);
    chk("R8 pull released", 32'(ack_pull_sda), 32'd0);
  endtask

  initial begin
    #100000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; scl_in = 1'b1; sda_in = 1'b1; frame_active = 1'b0;
    start_pulse = 1'b0; rd_en = 1'b0; ack_wr = 1'b0; ack_nack = 1'b0;
    exp_shift = 8'h00;
    wait_n(3);
    chk("R1 rd_data in reset", 32'(rd_data), 32'd0);
    rst_n = 1'b1;
    wait_n(2);
    chk("R1 hold after reset", 32'(hold_scl), 32'd0);
    chk("R1 pull after reset", 32'(ack_pull_sda), 32'd0);
    do_read();
    chk("R1 snapshot after reset", 32'(rd_data), 32'h0000);

    // START, SCL goes low, frame begins
    scl_in = 1'b0;
    wait_n(4);
    start_pulse = 1'b1; @(negedge clk); start_pulse = 1'b0;
    frame_active = 1'b1;

    for (int v = 0; v < 6; v++) begin
      for (int b = 7; b >= 0; b--) begin
        send_data_bit(VEC[v][b+1]);
        do_read();
        if (b > 0) begin
          chk("R4 count/data word", 32'(rd_data), {16'h0, 4'h0, 4'(8 - b), exp_shift});
        end else begin
          chk("R5 done word", 32'(rd_data), {16'h0, 8'h0F, VEC[v][8:1]});
          chk("R2 MSB-first byte", 32'(rd_data[7:0]), 32'(VEC[v][8:1]));
          chk("R5 hold raised", 32'(hold_scl), 32'd1);
        end
      end
      ack_write(VEC[v][0]);
      chk("R7 hold released", 32'(hold_scl), 32'd0);
      chk("R7 pull after choice", 32'(ack_pull_sda), 32'(!VEC[v][0]));
      ninth_clock(VEC[v][0]);
      do_read();
      chk("R8 counter back to zero", 32'(rd_data), {16'h0, 8'h00, VEC[v][8:1]});
    end

    // R9: ack choice while no byte waits
    ack_write(1'b0);
    wait_n(2);
    chk("R9 idle ack ignored pull", 32'(ack_pull_sda), 32'd0);
    chk("R9 idle ack hold", 32'(hold_scl), 32'd0);
    do_read();
    chk("R9 idle ack state", 32'(rd_data), {16'h0, 8'h00, exp_shift});

    // R3: edges without frame
    frame_active = 1'b0;
    scl_pulse(1'b1); scl_pulse(1'b0); scl_pulse(1'b1);
    do_read();
    chk("R3 frame low ignored", 32'(rd_data), {16'h0, 8'h00, exp_shift});
    frame_active = 1'b1;

    // R10: start mid-byte
    send_data_bit(1'b1); send_data_bit(1'b0); send_data_bit(1'b1);
    start_pulse = 1'b1; @(negedge clk); start_pulse = 1'b0;
    do_read();
    chk("R10 start mid-byte", 32'(rd_data), {16'h0, 8'h00, exp_shift});

    // R6 and R10: edges during hold, then start clears hold
    for (int b = 7; b >= 0; b--) send_data_bit(1'(b & 1));
    scl_pulse(1'b1); scl_pulse(1'b0);
    do_read();
    chk("R6 edges in hold", 32'(rd_data), {16'h0, 8'h0F, exp_shift});
    chk("R6 hold kept", 32'(hold_scl), 32'd1);
    start_pulse = 1'b1; @(negedge clk); start_pulse = 1'b0;
    chk("R10 start clears hold", 32'(hold_scl), 32'd0);
    do_read();
    chk("R10 start clears count", 32'(rd_data), {16'h0, 8'h00, exp_shift});

    // R11: read on the same edge as a shift
    sda_in = 1'b1;
    wait_n(4);
    scl_in = 1'b1;          // sync stage 1 at next edge, stage 2 at the one after
    @(negedge clk);
    @(negedge clk);         // rise now visible; shift lands at coming edge
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R11 coincident read pre-shift", 32'(rd_data), {16'h0, 8'h00, exp_shift});
    exp_shift = {exp_shift[6:0], 1'b1};
    do_read();
    chk("R11 following read post-shift", 32'(rd_data), {16'h0, 8'h01, exp_shift});
    wait_n(2);
    chk("R11 word held without read", 32'(rd_data), {16'h0, 8'h01, exp_shift});
    scl_in = 1'b0;
    wait_n(4);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule